// File: doc/BRIEF.md
# Fused Shift-Mask Logic Unit

This block is a three-source integer logic unit for 32-bit operands. In one step it shifts one operand by a variable amount and merges the shifted value with a third operand, using either AND (masking) or OR (merging). A fifth operation ANDs two sources and then ORs the result with the third. A shifter-plus-logic sequence that would otherwise take two dependent operations becomes a single one.

A 3-bit opcode selects the operation. `src1` supplies the shift amount, or the first AND operand for the AND-then-OR operation. `src2` is the value that is shifted or masked. `src3` is the merge operand. The `REG_OUT` parameter selects the output variant:

- With `REG_OUT` = 1 (the default), a result register holds each result. The result appears one clock after a valid input, together with a valid flag.
- With `REG_OUT` = 0, the unit is purely combinational. In this variant `out_valid` follows `in_valid`.

Top module: `shmask_unit`

## Requirements
- R1: Opcode 0 (shift right, mask) yields (src2 logically shifted right by the shift amount) AND src3.
- R2: Opcode 1 (shift left, mask) yields (src2 shifted left by the shift amount) AND src3.
- R3: Opcode 2 (shift right, merge) yields (src2 logically shifted right by the shift amount) OR src3.
- R4: Opcode 3 (shift left, merge) yields (src2 shifted left by the shift amount) OR src3.
- R5: Opcode 4 (and, merge) yields (src2 AND src1) OR src3, using all 32 bits of src1.
- R6: The shift amount is src1 bits [4:0] only, covering 0 to 31. Bits [31:5] of src1 have no effect on the four shift operations.
- R7: Right shifts fill the vacated upper bits with zeros, whatever the state of src2 bit 31.
- R8: Opcodes 5, 6 and 7 yield a result of zero.
- R9: In registered mode, an input presented with in_valid high produces its result and out_valid high exactly one clock later. Accepting a new input in the cycle where the previous result is shown is allowed, so one result can be produced per clock.
- R10: After reset, out_valid is 0 and result is 0.
- R11: In registered mode, a cycle with in_valid low drives out_valid low in the following cycle. The result keeps the last computed value, whatever the source inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operands and opcode are valid this cycle |
| opcode | input | 3 | Operation select (0 to 4 used, 5 to 7 give zero) |
| src1 | input | 32 | Shift amount (low 5 bits) or first AND operand |
| src2 | input | 32 | Value that is shifted or masked |
| src3 | input | 32 | Merge operand for the final AND or OR |
| out_valid | output | 1 | Result is valid |
| result | output | 32 | Operation result |

## Verification
In registered mode, two things can coincide in one clock: the unit emits a result and captures the next operation. The bench provokes this by issuing operations back to back with no idle cycle between them. A scoreboard queue holds the expected values, and each emitted result is compared in order against the value the bench computed for that issue. The opposite case is also driven: idle cycles with changing source inputs. It is judged by checking that out_valid drops while the result stays frozen at the last computed value.

// File: rtl/shmask_pkg.sv
package shmask_pkg;

    localparam int DATA_W = 32;
    localparam int OP_W   = 3;

    typedef enum logic [OP_W-1:0] {
        OP_SHR_AND = 3'd0,
        OP_SHL_AND = 3'd1,
        OP_SHR_OR  = 3'd2,
        OP_SHL_OR  = 3'd3,
        OP_AND_OR  = 3'd4
    } op_e;

endpackage

// File: rtl/shmask_shifter.sv
// Logarithmic barrel shifter, one mux stage per bit of the shift amount.
module shmask_shifter #(
    parameter int WIDTH = 32,
    parameter bit LEFT  = 1'b0
) (
    input  logic [WIDTH-1:0]         data_i,
    input  logic [$clog2(WIDTH)-1:0] amt_i,
    output logic [WIDTH-1:0]         data_o
);
    localparam int SH_W = $clog2(WIDTH);

    logic [WIDTH-1:0] stage [0:SH_W];

    assign stage[0] = data_i;

    for (genvar k = 0; k < SH_W; k++) begin : g_stage
        localparam int STEP = 1 << k;
        if (LEFT) begin : g_left
            assign stage[k+1] = amt_i[k] ? {stage[k][WIDTH-1-STEP:0], {STEP{1'b0}}}
                                         : stage[k];
        end else begin : g_right
            assign stage[k+1] = amt_i[k] ? {{STEP{1'b0}}, stage[k][WIDTH-1:STEP]}
                                         : stage[k];
        end
    end

    assign data_o = stage[SH_W];

    // Bits vacated by the shift must be zero (R7 for the right shifter).
    always_comb begin
        if (LEFT) begin
            p_left_fill_r2 : assert ((data_o & ~({WIDTH{1'b1}} << amt_i)) == '0);
        end else begin
            p_zero_fill_r7 : assert ((data_o & ~({WIDTH{1'b1}} >> amt_i)) == '0);
        end
    end

endmodule

// File: rtl/shmask_merge.sv
// Selects the fused result for the opcode.
module shmask_merge
    import shmask_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [OP_W-1:0]  op_i,
    input  logic [WIDTH-1:0] src1_i,
    input  logic [WIDTH-1:0] src2_i,
    input  logic [WIDTH-1:0] src3_i,
    input  logic [WIDTH-1:0] shr_i,
    input  logic [WIDTH-1:0] shl_i,
    output logic [WIDTH-1:0] res_o
);
    always_comb begin
        unique case (op_i)
            OP_SHR_AND: res_o = shr_i & src3_i;
            OP_SHL_AND: res_o = shl_i & src3_i;
            OP_SHR_OR:  res_o = shr_i | src3_i;
            OP_SHL_OR:  res_o = shl_i | src3_i;
            OP_AND_OR:  res_o = (src2_i & src1_i) | src3_i;
            default:    res_o = '0;
        endcase
    end

    // Merge operand shapes the result for every defined opcode.
    always_comb begin
        if (op_i == OP_SHR_AND || op_i == OP_SHL_AND) begin
            p_mask_subset_r1 : assert ((res_o & ~src3_i) == '0);
        end
        if (op_i == OP_SHR_OR || op_i == OP_SHL_OR || op_i == OP_AND_OR) begin
            p_merge_superset_r3 : assert ((res_o & src3_i) == src3_i);
        end
    end

endmodule

// File: rtl/shmask_unit.sv
module shmask_unit
    import shmask_pkg::*;
#(
    parameter int WIDTH   = DATA_W,
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [OP_W-1:0]  opcode,
    input  logic [WIDTH-1:0] src1,
    input  logic [WIDTH-1:0] src2,
    input  logic [WIDTH-1:0] src3,
    output logic             out_valid,
    output logic [WIDTH-1:0] result
);
    localparam int SH_W = $clog2(WIDTH);

    typedef struct packed {
        logic             valid;
        logic [WIDTH-1:0] data;
    } out_t;

    logic [SH_W-1:0]  shamt;
    logic [WIDTH-1:0] shr_c;
    logic [WIDTH-1:0] shl_c;
    logic [WIDTH-1:0] res_c;

    assign shamt = src1[SH_W-1:0];

    shmask_shifter #(.WIDTH(WIDTH), .LEFT(1'b0)) u_shr (
        .data_i (src2),
        .amt_i  (shamt),
        .data_o (shr_c)
    );

    shmask_shifter #(.WIDTH(WIDTH), .LEFT(1'b1)) u_shl (
        .data_i (src2),
        .amt_i  (shamt),
        .data_o (shl_c)
    );

    shmask_merge #(.WIDTH(WIDTH)) u_merge (
        .op_i   (opcode),
        .src1_i (src1),
        .src2_i (src2),
        .src3_i (src3),
        .shr_i  (shr_c),
        .shl_i  (shl_c),
        .res_o  (res_c)
    );

    if (REG_OUT) begin : g_reg
        out_t st_d, st_q;

        always_comb begin
            st_d       = st_q;
            st_d.valid = in_valid;
            if (in_valid) begin
                st_d.data = res_c;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q <= '0;
            end else begin
                st_q <= st_d;
            end
        end

        assign out_valid = st_q.valid;
        assign result    = st_q.data;

        p_valid_follows_r9 : assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);

        p_idle_hold_r11 : assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> (!out_valid && $stable(result)));

        p_unused_zero_r8 : assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && opcode > OP_AND_OR) |=> (result == '0));

        p_and_or_r5 : assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && opcode == OP_AND_OR)
                |=> (result == (($past(src2) & $past(src1)) | $past(src3))));
    end else begin : g_comb
        assign out_valid = in_valid;
        assign result    = res_c;
    end

endmodule

// File: tb/shmask_unit_bench.sv
module shmask_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  opcode = '0;
    logic [31:0] src1 = '0;
    logic [31:0] src2 = '0;
    logic [31:0] src3 = '0;
    logic        out_valid;
    logic [31:0] result;

    int          n_checks = 0;
    int          n_fails  = 0;
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #10 clk = ~clk;

    shmask_unit u_shmask_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .opcode    (opcode),
        .src1      (src1),
        .src2      (src2),
        .src3      (src3),
        .out_valid (out_valid),
        .result    (result)
    );

    function automatic logic [31:0] model(input logic [2:0] op,
                                          input logic [31:0] a, b, c);
        int sh = int'(a[4:0]);
        case (op)
            3'd0:    return (b >> sh) & c;
            3'd1:    return (b << sh) & c;
            3'd2:    return (b >> sh) | c;
            3'd3:    return (b << sh) | c;
            3'd4:    return (b & a) | c;
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Driver: called at a falling edge, holds the input for one rising edge.
    task automatic issue(input logic [2:0] op, input logic [31:0] a, b, c, input string tag);
        in_valid = 1'b1;
        opcode   = op;
        src1     = a;
        src2     = b;
        src3     = c;
        exp_q.push_back(model(op, a, b, c));
        tag_q.push_back(tag);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Monitor: one clock after capture, the result is visible at the falling edge.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check("R9 unexpected out_valid", 32'h1, 32'h0);
            end else begin
                check(tag_q.pop_front(), result, exp_q.pop_front());
            end
        end
    end

    initial begin
        #(20 * 200000);
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R10 out_valid after reset", {31'h0, out_valid}, 32'h0);
        check("R10 result after reset", result, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 out_valid idle", {31'h0, out_valid}, 32'h0);

        // Directed cases, issued back to back (R9).
        issue(3'd0, 32'd4,  32'hF0F0_1234, 32'h0FFF_FFFF, "R1 shr-and amt 4");
        issue(3'd1, 32'd8,  32'h00AB_CDEF, 32'hFFFF_0000, "R2 shl-and amt 8");
        issue(3'd2, 32'd16, 32'hDEAD_BEEF, 32'h1000_0001, "R3 shr-or amt 16");
        issue(3'd3, 32'd31, 32'h0000_0003, 32'h0000_00F0, "R4 shl-or amt 31");
        issue(3'd4, 32'hFF00_FF00, 32'h1234_5678, 32'h0000_000F, "R5 and-or");
        issue(3'd0, 32'd0,  32'hCAFE_F00D, 32'hFFFF_FFFF, "R1 shr-and amt 0");
        issue(3'd3, 32'd0,  32'h8000_0001, 32'h0, "R4 shl-or amt 0");
        issue(3'd2, 32'hFFFF_FFE3, 32'h0000_0F00, 32'h0, "R6 high src1 bits ignored right");
        issue(3'd1, 32'h8000_0025, 32'h0000_0001, 32'hFFFF_FFFF, "R6 high src1 bits ignored left");
        issue(3'd0, 32'd31, 32'h8000_0000, 32'hFFFF_FFFF, "R7 zero fill amt 31");
        issue(3'd2, 32'd1,  32'hFFFF_FFFF, 32'h0, "R7 zero fill amt 1");
        issue(3'd5, 32'd3,  32'hFFFF_FFFF, 32'hFFFF_FFFF, "R8 opcode 5 zero");
        issue(3'd6, 32'd3,  32'hFFFF_FFFF, 32'hFFFF_FFFF, "R8 opcode 6 zero");
        issue(3'd7, 32'd3,  32'hFFFF_FFFF, 32'hFFFF_FFFF, "R8 opcode 7 zero");

        // Idle with changing sources: output must freeze (R11).
        issue(3'd4, 32'hFFFF_FFFF, 32'h0000_5A5A, 32'h0, "R5 before idle");
        src1 = 32'h1; src2 = 32'hFFFF_FFFF; src3 = 32'h1234_0000; opcode = 3'd2;
        @(negedge clk);
        @(negedge clk);
        check("R11 out_valid low when idle", {31'h0, out_valid}, 32'h0);
        check("R11 result held when idle", result, 32'h0000_5A5A);

        // Every shift amount for both directions and both merges.
        for (int s = 0; s < 32; s++) begin
            issue(3'(s % 4), 32'(s) | (32'(s) << 8), 32'h9E37_79B9, 32'h5555_AAAA, "R1-R4 sweep");
        end

        // Random operations with gaps of random length.
        for (int i = 0; i < 300; i++) begin
            issue(3'($urandom_range(0, 7)), $urandom, $urandom, $urandom, "R9 random stream");
            if ($urandom_range(0, 3) == 0) begin
                @(negedge clk);
            end
        end

        repeat (3) @(negedge clk);
        check("R9 all results emitted", 32'(exp_q.size()), 32'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule